// File: doc/BRIEF.md
# Class-Pair Issue Interlock

This unit sits at the issue point of an in-order pipeline and decides, cycle by cycle, whether the instruction at its input may issue. Each instruction carries a class code, an optional destination register and up to two optional source registers. The unit remembers the instructions issued during the last few cycles. It compares the sources of the waiting instruction against those recent producers. The instruction is held until the spacing required for that particular producer class and consumer class has elapsed.

The required spacing is looked up per pair of classes rather than taken from one fixed forwarding rule. A branch that tests a freshly computed integer value pays its own one-cycle penalty. Each branch owns one delay slot. The next instruction fills the slot only if it is marked as a slot filler. Otherwise the slot cycle is spent as a stall.

The upstream stage holds the instruction stable while `stall_o` is high and presents the next one after the cycle in which `issue_o` is high. Forwarding paths and the datapath itself lie outside this unit. Only the timing decision is made here.

Top module: `latency_interlock`

## Requirements
- R1: Reset clears the producer history and any pending delay slot, and `issue_o` stays low while `rst` is high. After reset, the first instruction issues at once with `stall_cnt_o` = 0.
- R2: Class codes are FP ALU = 0, load double = 1, store double = 2, integer ALU = 3, branch = 4. An FP ALU consumer of an FP ALU result issues 4 cycles after the producer (3 stall cycles), and `stall_cnt_o` reads 3 in the first waiting cycle.
- R3: A store double whose data source (source 2) reads an FP ALU result issues 3 cycles after the producer. The store's address source (source 1) never causes a wait.
- R4: A load double result used by an FP ALU operation costs 1 stall cycle. The same result used as store-double data costs none.
- R5: An integer ALU result used by another integer ALU operation costs no stall. An instruction with no dependence on a recent producer issues in the cycle it is presented.
- R6: A branch testing the register written by the integer ALU operation issued in the cycle just before it waits 1 cycle. A branch testing an unrelated register does not wait.
- R7: In the cycle after a branch issues, an instruction without the slot-filler flag (`in_dslot` = 0) cannot issue. That slot cycle is a stall and the instruction issues one cycle later. A marked filler that has no hazard issues in that slot cycle.
- R8: A marked filler that has a data hazard waits out its latency in the slot. No extra slot stall is added on top of that wait.
- R9: When both sources depend on recent producers, `stall_cnt_o` equals the larger of the two remaining latencies, and the instruction issues that many cycles later.
- R10: When several recent producers wrote the same register, only the most recently issued one sets the required spacing.
- R11: A load/add/store/decrement/branch loop with no delay-slot filler repeats every 10 cycles. The reordered version of the same loop, with the store in the delay slot, repeats every 6 cycles.
- R12: `issue_o` and `stall_o` are never high together. `stall_o` equals `in_valid` and not `issue_o`, and `issue_o` is never high when `stall_cnt_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_cls | input | 3 | Class code of the presented instruction |
| in_dst | input | REG_W | Destination register (used by FP ALU, load and integer classes) |
| in_s1_vld | input | 1 | Source 1 is used |
| in_s1 | input | REG_W | Source 1 register (address base for a store) |
| in_s2_vld | input | 1 | Source 2 is used |
| in_s2 | input | REG_W | Source 2 register (data for a store) |
| in_dslot | input | 1 | Instruction may fill a branch delay slot |
| issue_o | output | 1 | Instruction issues at this clock edge |
| stall_o | output | 1 | Instruction is presented but held this cycle |
| stall_cnt_o | output | CNT_W | Data-hazard cycles still to wait, including this one |

## Verification
The hardest situation to reach from the ports is a dependence on a register that has been written more than once within the three-cycle window. The unit must then use the youngest writer and ignore an older, slower one. Another case of this kind is a delay-slot filler that also carries a data hazard. Directed sequences build both cases on purpose. A long stream of random instructions also reaches them often, because it draws from only three integer and four FP registers, mixes all five classes, sets the filler flag at random and inserts an idle cycle now and then.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CL_FPU = 3'd0,
    CL_LDD = 3'd1,
    CL_STD = 3'd2,
    CL_INT = 3'd3,
    CL_BR  = 3'd4
  } cls_e;

  localparam int MAX_LAT = 3;

  // stall cycles required between a producer and a directly following consumer role
  function automatic int pair_lat(cls_e prod, cls_e role);
    int l;
    l = 0;
    case (prod)
      CL_FPU: begin
        if (role == CL_FPU) l = 3;
        else if (role == CL_STD) l = 2;
      end
      CL_LDD: if (role == CL_FPU) l = 1;
      CL_INT: if (role == CL_BR) l = 1;
      default: l = 0;
    endcase
    return l;
  endfunction

  function automatic logic has_dst(cls_e c);
    return (c == CL_FPU) || (c == CL_LDD) || (c == CL_INT);
  endfunction

  // a store's first source is an address base and behaves as an integer consumer
  function automatic cls_e src_role(cls_e c, int idx);
    cls_e r;
    r = c;
    if (c == CL_STD && idx == 0) r = CL_INT;
    return r;
  endfunction

endpackage

// File: rtl/ilk_history.sv
module ilk_history #(
  parameter int HIST  = 3,
  parameter int REG_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push_vld,
  input  ilk_pkg::cls_e          push_cls,
  input  logic [REG_W-1:0]       push_dst,
  output logic [HIST-1:0]        h_vld,
  output ilk_pkg::cls_e          h_cls [HIST],
  output logic [REG_W-1:0]       h_dst [HIST]
);
  import ilk_pkg::*;

  // slot k holds the instruction issued k+1 cycles ago (or a bubble)
  generate
    for (genvar k = 0; k < HIST; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          h_vld[k] <= 1'b0;
          h_cls[k] <= CL_INT;
          h_dst[k] <= '0;
        end else if (k == 0) begin
          h_vld[k] <= push_vld;
          h_cls[k] <= push_cls;
          h_dst[k] <= push_dst;
        end else begin
          h_vld[k] <= h_vld[k-1];
          h_cls[k] <= h_cls[k-1];
          h_dst[k] <= h_dst[k-1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ilk_src_wait.sv
module ilk_src_wait #(
  parameter int HIST  = 3,
  parameter int REG_W = 6,
  parameter int CNT_W = 2
) (
  input  logic                   src_vld,
  input  logic [REG_W-1:0]       src,
  input  ilk_pkg::cls_e          role,
  input  logic [HIST-1:0]        h_vld,
  input  ilk_pkg::cls_e          h_cls [HIST],
  input  logic [REG_W-1:0]       h_dst [HIST],
  output logic [CNT_W-1:0]       need
);
  import ilk_pkg::*;

  // scan oldest to youngest so the youngest matching writer decides
  always_comb begin
    need = '0;
    for (int k = HIST - 1; k >= 0; k--) begin
      if (src_vld && h_vld[k] && (h_dst[k] == src)) begin
        automatic int l = pair_lat(h_cls[k], role);
        if (l > k) need = CNT_W'(l - k);
        else       need = '0;
      end
    end
  end

endmodule

// File: rtl/ilk_dslot_ctl.sv
module ilk_dslot_ctl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_dslot,
  input  logic issue,
  input  logic issue_is_br,
  output logic blk
);
  logic pend;

  assign blk = pend && in_valid && !in_dslot;

  always_ff @(posedge clk) begin
    if (rst)                              pend <= 1'b0;
    else if (issue)                       pend <= issue_is_br;
    else if (pend && (!in_valid || !in_dslot)) pend <= 1'b0;
  end

endmodule

// File: rtl/latency_interlock.sv
module latency_interlock #(
  parameter int REG_W = 6,
  parameter int HIST  = ilk_pkg::MAX_LAT,
  parameter int CNT_W = $clog2(ilk_pkg::MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_s1_vld,
  input  logic [REG_W-1:0] in_s1,
  input  logic             in_s2_vld,
  input  logic [REG_W-1:0] in_s2,
  input  logic             in_dslot,
  output logic             issue_o,
  output logic             stall_o,
  output logic [CNT_W-1:0] stall_cnt_o
);
  import ilk_pkg::*;

  localparam int NSRC = 2;

  cls_e             cls;
  logic [HIST-1:0]  h_vld;
  cls_e             h_cls [HIST];
  logic [REG_W-1:0] h_dst [HIST];
  logic [CNT_W-1:0] need  [NSRC];
  logic             src_v [NSRC];
  logic [REG_W-1:0] src_r [NSRC];
  logic             slot_blk;

  assign cls      = cls_e'(in_cls);
  assign src_v[0] = in_s1_vld;
  assign src_v[1] = in_s2_vld;
  assign src_r[0] = in_s1;
  assign src_r[1] = in_s2;

  ilk_history #(.HIST(HIST), .REG_W(REG_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .push_vld (issue_o && has_dst(cls)),
    .push_cls (cls),
    .push_dst (in_dst),
    .h_vld    (h_vld),
    .h_cls    (h_cls),
    .h_dst    (h_dst)
  );

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      ilk_src_wait #(.HIST(HIST), .REG_W(REG_W), .CNT_W(CNT_W)) u_wait (
        .src_vld (src_v[s]),
        .src     (src_r[s]),
        .role    (src_role(cls, s)),
        .h_vld   (h_vld),
        .h_cls   (h_cls),
        .h_dst   (h_dst),
        .need    (need[s])
      );
    end
  endgenerate

  ilk_dslot_ctl u_slot (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_dslot    (in_dslot),
    .issue       (issue_o),
    .issue_is_br (cls == CL_BR),
    .blk         (slot_blk)
  );

  assign stall_cnt_o = (need[0] > need[1]) ? need[0] : need[1];
  assign issue_o     = in_valid && !rst && (stall_cnt_o == '0) && !slot_blk;
  assign stall_o     = in_valid && !issue_o;

endmodule

// File: rtl/latency_interlock_chk.sv
module latency_interlock_chk #(
  parameter int REG_W = 6,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       in_cls,
  input logic [REG_W-1:0] in_dst,
  input logic             in_s1_vld,
  input logic [REG_W-1:0] in_s1,
  input logic             in_dslot,
  input logic             issue_o,
  input logic             stall_o,
  input logic [CNT_W-1:0] stall_cnt_o
);

  assert_issue_stall_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(issue_o && stall_o));

  assert_cnt_blocks_R12: assert property (@(posedge clk) disable iff (rst)
    (stall_cnt_o != '0) |-> !issue_o);

  assert_fp_chain_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(issue_o) && $past(in_cls) == 3'd0 && in_valid && in_cls == 3'd0 &&
     in_s1_vld && in_s1 == $past(in_dst)) |-> !issue_o);

  assert_branch_int_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(issue_o) && $past(in_cls) == 3'd3 && in_valid && in_cls == 3'd4 &&
     in_s1_vld && in_s1 == $past(in_dst)) |-> !issue_o);

  assert_slot_nonfiller_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(issue_o) && $past(in_cls) == 3'd4 && in_valid && !in_dslot) |-> !issue_o);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stall_cnt_o == '0));

endmodule

bind latency_interlock latency_interlock_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_cls      (in_cls),
  .in_dst      (in_dst),
  .in_s1_vld   (in_s1_vld),
  .in_s1       (in_s1),
  .in_dslot    (in_dslot),
  .issue_o     (issue_o),
  .stall_o     (stall_o),
  .stall_cnt_o (stall_cnt_o)
);

// File: tb/latency_interlock_tb.sv
`timescale 1ns/100ps
module latency_interlock_tb;
  localparam int REG_W = 6;
  localparam int CNT_W = 2;
  localparam int FP = 0, LD = 1, ST = 2, IN = 3, BR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_s1_vld = 1'b0, in_s2_vld = 1'b0, in_dslot = 1'b0;
  logic [2:0] in_cls = '0;
  logic [REG_W-1:0] in_dst = '0, in_s1 = '0, in_s2 = '0;
  logic issue_o, stall_o;
  logic [CNT_W-1:0] stall_cnt_o;

  int ntests = 0, nfail = 0, cyc = 0;
  int m_t [64];
  int m_c [64];
  bit m_k [64];
  int last_t = -10, last_cls = -1;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  latency_interlock #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_dst(in_dst),
    .in_s1_vld(in_s1_vld), .in_s1(in_s1), .in_s2_vld(in_s2_vld), .in_s2(in_s2),
    .in_dslot(in_dslot), .issue_o(issue_o), .stall_o(stall_o), .stall_cnt_o(stall_cnt_o)
  );

  function automatic int lat_ref(int p, int c);
    if (p == FP && c == FP) return 3;
    if (p == FP && c == ST) return 2;
    if (p == LD && c == FP) return 1;
    if (p == IN && c == BR) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
  endtask

  // present one instruction, wait for issue, compare timing with the model
  task automatic op(int cls, int dst, int s1v, int s1, int s2v, int s2, int dsl,
                    string tag, output int t, output int cnt0);
    int pres, dr, exp_t, w;
    bit first;
    @(negedge clk);
    in_valid = 1'b1; in_cls = 3'(cls); in_dst = REG_W'(dst);
    in_s1_vld = 1'(s1v); in_s1 = REG_W'(s1);
    in_s2_vld = 1'(s2v); in_s2 = REG_W'(s2); in_dslot = 1'(dsl);
    pres = cyc; dr = pres;
    if (s1v != 0 && m_k[s1]) begin
      int r = m_t[s1] + 1 + lat_ref(m_c[s1], (cls == ST) ? IN : cls);
      if (r > dr) dr = r;
    end
    if (s2v != 0 && m_k[s2]) begin
      int r = m_t[s2] + 1 + lat_ref(m_c[s2], cls);
      if (r > dr) dr = r;
    end
    exp_t = dr;
    if (last_cls == BR && last_t == pres - 1 && dsl == 0 && exp_t < pres + 1) exp_t = pres + 1;
    first = 1'b1; w = 0; cnt0 = 0;
    forever begin
      #1;
      if (first) begin
        cnt0 = int'(stall_cnt_o);
        chk(cnt0 == dr - pres, {tag, " stall count"}, cnt0, dr - pres);
        first = 1'b0;
      end
      chk(stall_o == !issue_o, "R12 stall/issue", int'(stall_o), int'(!issue_o));
      if (issue_o) break;
      w++;
      if (w > 10) begin
        chk(1'b0, {tag, " hung"}, w, exp_t - pres);
        break;
      end
      @(negedge clk);
    end
    t = cyc;
    chk(t - pres == exp_t - pres, {tag, " issue delay"}, t - pres, exp_t - pres);
    if (cls == FP || cls == LD || cls == IN) begin
      m_k[dst] = 1'b1; m_t[dst] = t; m_c[dst] = cls;
    end
    last_cls = cls; last_t = t;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    summary();
    $finish;
  end

  initial begin
    int t0, t1, t2, c, a, b, prev;
    int lds [4];
    void'($urandom(32'd4321));
    for (int i = 0; i < 64; i++) m_k[i] = 1'b0;

    // R1: reset holds issue low, then clean start
    repeat (2) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_cls = 3'(IN);
    #1 chk(issue_o == 1'b0, "R1 issue during reset", int'(issue_o), 0);
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    in_valid = 1'b0;
    op(FP, 33, 1, 34, 1, 35, 0, "R1", t0, c);
    chk(c == 0, "R1 first count", c, 0);

    // R2: FP -> FP
    idle(); idle(); idle();
    op(FP, 33, 1, 34, 1, 35, 0, "R2", t0, c);
    op(FP, 36, 1, 33, 1, 34, 0, "R2", t1, c);
    chk(t1 - t0 == 4, "R2 spacing", t1 - t0, 4);
    chk(c == 3, "R2 count", c, 3);

    // R3: FP -> store data, store address never waits
    op(FP, 33, 1, 34, 1, 35, 0, "R3", t0, c);
    op(ST, 0, 1, 1, 1, 33, 0, "R3", t1, c);
    chk(t1 - t0 == 3, "R3 spacing", t1 - t0, 3);
    op(FP, 2, 1, 34, 1, 35, 0, "R3", t0, c);
    op(ST, 0, 1, 2, 1, 35, 0, "R3", t1, c);
    chk(t1 - t0 == 1, "R3 address source", t1 - t0, 1);

    // R4: load -> FP and load -> store data
    op(LD, 34, 1, 1, 0, 0, 0, "R4", t0, c);
    op(FP, 35, 1, 34, 1, 36, 0, "R4", t1, c);
    chk(t1 - t0 == 2, "R4 load to FP", t1 - t0, 2);
    idle(); idle(); idle();
    op(LD, 34, 1, 1, 0, 0, 0, "R4", t0, c);
    op(ST, 0, 1, 1, 1, 34, 0, "R4", t1, c);
    chk(t1 - t0 == 1, "R4 load to store", t1 - t0, 1);

    // R5: int -> int, independent
    op(IN, 2, 1, 2, 0, 0, 0, "R5", t0, c);
    op(IN, 3, 1, 2, 1, 1, 0, "R5", t1, c);
    chk(t1 - t0 == 1, "R5 spacing", t1 - t0, 1);

    // R6: int -> branch
    op(IN, 2, 1, 1, 0, 0, 0, "R6", t0, c);
    op(BR, 0, 1, 2, 0, 0, 0, "R6", t1, c);
    chk(t1 - t0 == 2, "R6 spacing", t1 - t0, 2);
    op(IN, 3, 1, 1, 0, 0, 1, "R6", t0, c);
    op(IN, 2, 1, 1, 0, 0, 0, "R6", t0, c);
    op(BR, 0, 1, 3, 0, 0, 0, "R6", t1, c);
    chk(t1 - t0 == 1, "R6 unrelated", t1 - t0, 1);

    // R7: delay slot, non-filler vs filler
    op(IN, 1, 1, 1, 0, 0, 1, "R7", t0, c);
    op(BR, 0, 1, 3, 0, 0, 0, "R7", t0, c);
    op(IN, 2, 1, 1, 0, 0, 0, "R7", t1, c);
    chk(t1 - t0 == 2, "R7 unfilled slot", t1 - t0, 2);
    op(BR, 0, 1, 3, 0, 0, 0, "R7", t0, c);
    op(IN, 2, 1, 1, 0, 0, 1, "R7", t1, c);
    chk(t1 - t0 == 1, "R7 filled slot", t1 - t0, 1);

    // R8: filler with a data hazard
    op(FP, 33, 1, 34, 1, 35, 0, "R8", t0, c);
    op(BR, 0, 1, 1, 0, 0, 0, "R8", t1, c);
    op(ST, 0, 1, 1, 1, 33, 1, "R8", t2, c);
    chk(t2 - t0 == 3, "R8 filler spacing", t2 - t0, 3);

    // R9: two sources, larger remaining latency wins
    op(FP, 36, 1, 34, 1, 35, 0, "R9", t0, c);
    op(LD, 37, 1, 1, 0, 0, 0, "R9", t1, c);
    op(FP, 38, 1, 37, 1, 36, 0, "R9", t2, c);
    chk(c == 2, "R9 count", c, 2);
    chk(t2 - t0 == 4, "R9 spacing", t2 - t0, 4);

    // R10: youngest writer decides
    op(FP, 33, 1, 34, 1, 35, 0, "R10", t0, c);
    op(LD, 33, 1, 1, 0, 0, 0, "R10", t1, c);
    op(FP, 36, 1, 33, 0, 0, 0, "R10", t2, c);
    chk(c == 1, "R10 count", c, 1);
    chk(t2 - t1 == 2, "R10 spacing", t2 - t1, 2);

    // R11: naive loop, 10 cycles per pass (R1=1, F0=32, F2=34, F4=36)
    idle(); idle(); idle();
    for (int it = 0; it < 3; it++) begin
      op(LD, 32, 1, 1, 0, 0, 0, "R11", lds[it], c);
      op(FP, 36, 1, 32, 1, 34, 0, "R11", a, c);
      op(ST, 0, 1, 1, 1, 36, 0, "R11", a, c);
      op(IN, 1, 1, 1, 0, 0, 0, "R11", a, c);
      op(BR, 0, 1, 1, 0, 0, 0, "R11", a, c);
    end
    op(LD, 32, 1, 1, 0, 0, 0, "R11", lds[3], c);
    for (int it = 0; it < 3; it++)
      chk(lds[it+1] - lds[it] == 10, "R11 naive loop", lds[it+1] - lds[it], 10);

    // R11: reordered loop with store in the slot, 6 cycles per pass
    idle(); idle(); idle();
    for (int it = 0; it < 3; it++) begin
      op(LD, 32, 1, 1, 0, 0, 0, "R11", lds[it], c);
      op(IN, 1, 1, 1, 0, 0, 0, "R11", a, c);
      op(FP, 36, 1, 32, 1, 34, 0, "R11", a, c);
      op(BR, 0, 1, 1, 0, 0, 0, "R11", a, c);
      op(ST, 0, 1, 1, 1, 36, 1, "R11", a, c);
    end
    op(LD, 32, 1, 1, 0, 0, 0, "R11", lds[3], c);
    for (int it = 0; it < 3; it++)
      chk(lds[it+1] - lds[it] == 6, "R11 reordered loop", lds[it+1] - lds[it], 6);

    // random mix, checked against the model (R9 spacing rules)
    prev = 0;
    for (int n = 0; n < 400; n++) begin
      int cl = int'($urandom_range(0, 4));
      int ir = int'($urandom_range(1, 3));
      int fr = 32 + int'($urandom_range(0, 3));
      int f2 = 32 + int'($urandom_range(0, 3));
      int i2 = int'($urandom_range(1, 3));
      int ds = int'($urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) idle();
      case (cl)
        FP: op(FP, fr, 1, f2, 1, 32 + int'($urandom_range(0, 3)), ds, "R9", b, c);
        LD: op(LD, fr, 1, ir, 0, 0, ds, "R9", b, c);
        ST: op(ST, 0, 1, ir, 1, f2, ds, "R9", b, c);
        IN: op(IN, ir, 1, i2, int'($urandom_range(0, 1)), int'($urandom_range(1, 3)), ds, "R9", b, c);
        default: op(BR, 0, 1, ir, 0, 0, ds, "R9", b, c);
      endcase
      prev = b;
    end

    idle();
    summary();
    $finish;
  end
endmodule